// File: doc/BRIEF.md
# Selectable Square-Wave Generator

This block turns a 32768 Hz tick enable into a square wave at one of sixteen rates picked by a 4-bit rate code. The rates run from 32768 Hz down to 0.5 Hz. It has its own divider chain, which is separate from any elapsed-time counter in the chip, so host writes to time registers elsewhere cannot disturb its phase. A power-fail input turns the pad driver off, and an enable bit forces the level low.

A sync-hold input clears the slow divider stages, the ones that produce 2048 Hz and below, and holds them at zero. The three fast stages keep running. When sync-hold is released, the slow waves restart from a known phase. Their first edge then lines up with the fast stages to within one 4096 Hz period, so software can align the slow waves with other tick-driven events.

Top module: `sqwave_sel`

## Requirements
- R1: While `rst_n` is sampled low, all divider stages clear, and `wave_out` and `wave_oe` read 0 one clock later.
- R2: With rate code 0, `wave_out` equals the `tick_32k` value of the previous clock.
- R3: Rate code c from 1 to 15 selects stage c of a 16-stage synchronous divider. Stage c has a period of 2^(c+1) ticks at 50% duty. Code 1 gives 8192 Hz, code 2 gives 4096 Hz, and codes 3 to 15 give 2048 Hz down to 0.5 Hz. No code gives 16384 Hz. The output is registered, with one clock of latency.
- R4: When `wave_en` is 0 and there is no power fail, `wave_out` is 0 and `wave_oe` is 1 one clock later.
- R5: When `pwr_fail` is 1, `wave_oe` is 0 and `wave_out` is 0 one clock later, whatever the value of `wave_en`.
- R6: While `sync_hold` is 1, stages 3 to 15 are cleared and held at 0, so a rate code from 3 to 15 reads 0.
- R7: Stages 0 to 2 keep counting ticks while `sync_hold` is 1, so codes 1 and 2 keep toggling.
- R8: After `sync_hold` is released, stage 3 and above advance only on a tick where stages 0 to 2 are all 1. With stages 0 to 2 at value L on release, code 3 first reads 1 after 8−L ticks, plus one clock of register latency.
- R9: The divider advances only on clocks where `tick_32k` is 1. Changes to `rate_sel`, `wave_en` or `pwr_fail` never alter its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_32k | input | 1 | One-clock enable pulse at 32768 Hz |
| rate_sel | input | 4 | Rate code |
| wave_en | input | 1 | Output enable bit; 0 forces the level low |
| sync_hold | input | 1 | Clears and holds the slow divider stages |
| pwr_fail | input | 1 | Power-fail indication; turns the driver off |
| wave_out | output | 1 | Square-wave level |
| wave_oe | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
Random stretches drive sparse and dense tick patterns with changing rate codes, enable, hold and power-fail levels. These show whether the divider advances only on ticks and whether its phase survives changes to the other inputs. A directed run with continuous ticks at code 15 counts clocks to the first rise and the next fall, which confirms the slowest stage's period. A directed release from sync-hold, at a known fast-stage phase, counts clocks to the first slow edge. This shows whether the slow stages restart from zero and carry only when the fast stages wrap.

// File: rtl/sqw_pkg.sv
// Shared sizing for the square-wave generator.
// Assumes the rate code width fixes the divider depth at 2**SEL_W stages.
package sqw_pkg;
    localparam int SEL_W  = 4;
    localparam int DIV_W  = 1 << SEL_W;
    localparam int FAST_N = 3;

    // Returns 1 when a rate code selects a stage cleared by sync-hold.
    function automatic logic is_slow_code(input logic [SEL_W-1:0] code);
        return (int'(code) >= FAST_N);
    endfunction
endpackage

// File: rtl/sqw_prescaler.sv
// Synchronous divider chain clocked by a tick enable.
// Stage k toggles when the tick and all lower stages are 1, so there is no ripple.
// Stages at index FAST_N and above are cleared and held while hold is set.
// Assumes tick is a single-clock pulse; a synchronous active-low reset clears all stages.
module sqw_prescaler #(
    parameter int DIV_W  = 16,
    parameter int FAST_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    output logic [DIV_W-1:0] stages
);
    logic [DIV_W-1:0] stage_q;
    logic [DIV_W-1:0] carry_in;

    // Carry chain: a stage may toggle only when every stage below it is 1.
    assign carry_in[0] = tick;
    generate
        for (genvar k = 1; k < DIV_W; k++) begin : g_carry
            assign carry_in[k] = carry_in[k-1] & stage_q[k-1];
        end
    endgenerate

    // Per-stage flop: fast stages always count; slow stages also obey hold.
    generate
        for (genvar k = 0; k < DIV_W; k++) begin : g_stage
            if (k < FAST_N) begin : g_fast
                always_ff @(posedge clk) begin
                    if (!rst_n)        stage_q[k] <= 1'b0;
                    else if (carry_in[k]) stage_q[k] <= ~stage_q[k];
                end
            end else begin : g_slow
                always_ff @(posedge clk) begin
                    if (!rst_n)           stage_q[k] <= 1'b0;
                    else if (hold)        stage_q[k] <= 1'b0;
                    else if (carry_in[k]) stage_q[k] <= ~stage_q[k];
                end
            end
        end
    endgenerate

    assign stages = stage_q;

    // R6
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (stage_q[DIV_W-1:FAST_N] == '0));

    // R7
    fast_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (stage_q[FAST_N-1:0] != $past(stage_q[FAST_N-1:0])));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(stage_q));
endmodule

// File: rtl/sqw_rate_mux.sv
// Picks the raw level for the selected rate.
// Code 0 passes the reference tick itself; code c from 1 up passes divider stage c.
// Assumes the stage vector has 2**SEL_W entries. Purely combinational.
module sqw_rate_mux #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 16
) (
    input  logic             tick,
    input  logic [SEL_W-1:0] code,
    input  logic [DIV_W-1:0] stages,
    output logic             level
);
    // Selection: the reference tick for code 0, otherwise the indexed stage.
    always_comb begin
        if (code == '0) level = tick;
        else            level = stages[code];
    end
endmodule

// File: rtl/sqw_out_stage.sv
// Registers the pad level and driver enable.
// Power fail turns the driver off and forces the level low; the enable bit forces the level low.
// Assumes a synchronous active-low reset, and that both outputs read 0 while in reset.
module sqw_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic en,
    input  logic pfail,
    output logic out,
    output logic oe
);
    // Output register: gated level plus driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= 1'b0;
            oe  <= 1'b0;
        end else begin
            out <= level & en & ~pfail;
            oe  <= ~pfail;
        end
    end

    // R5
    pfail_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfail |=> (!oe && !out));

    // R4
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pfail && !en) |=> (oe && !out));
endmodule

// File: rtl/sqwave_sel.sv
// Top of the selectable square-wave generator: divider chain, rate mux and output register.
// Assumes tick_32k is a one-clock pulse at 32768 Hz in the clk domain.
module sqwave_sel
    import sqw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_32k,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             wave_en,
    input  logic             sync_hold,
    input  logic             pwr_fail,
    output logic             wave_out,
    output logic             wave_oe
);
    logic [DIV_W-1:0] stages;
    logic             raw_level;

    sqw_prescaler #(.DIV_W(DIV_W), .FAST_N(FAST_N)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_32k),
        .hold   (sync_hold),
        .stages (stages)
    );

    sqw_rate_mux #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_mux (
        .tick   (tick_32k),
        .code   (rate_sel),
        .stages (stages),
        .level  (raw_level)
    );

    sqw_out_stage u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .level (raw_level),
        .en    (wave_en),
        .pfail (pwr_fail),
        .out   (wave_out),
        .oe    (wave_oe)
    );

    // R6
    slow_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hold && $past(sync_hold) && is_slow_code(rate_sel)) |=> !wave_out);
endmodule

// File: tb/sqwave_sel_tb.sv
module sqwave_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_32k;
    logic [3:0] rate_sel;
    logic       wave_en;
    logic       sync_hold;
    logic       pwr_fail;
    logic       wave_out;
    logic       wave_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Expected-value state, built from the requirements.
    logic [15:0] m_div;
    logic        e_out;
    logic        e_oe;
    logic        sel_prev;

    always #2.5 clk = ~clk;

    sqwave_sel u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .wave_en(wave_en), .sync_hold(sync_hold), .pwr_fail(pwr_fail),
        .wave_out(wave_out), .wave_oe(wave_oe)
    );

    function automatic logic exp_level(input logic [15:0] d, input logic [3:0] c, input logic t);
        return (c == 4'd0) ? t : d[c];
    endfunction

    function automatic string req_tag(input logic pf, input logic en, input logic [3:0] c, input logic h);
        if (pf)                  return "R5";
        if (!en)                 return "R4";
        if (c == 4'd0)           return "R2";
        if (h && c >= 4'd3)      return "R6";
        if (h)                   return "R7";
        return "R3/R9";
    endfunction

    // Reference model: output from the old divider state, then advance the divider.
    always @(posedge clk) begin
        logic [15:0] nxt;
        if (!rst_n) begin
            m_div = '0; e_out = 1'b0; e_oe = 1'b0;
        end else begin
            e_out = exp_level(m_div, rate_sel, tick_32k) & wave_en & ~pwr_fail;
            e_oe  = ~pwr_fail;
            nxt = tick_32k ? m_div + 16'd1 : m_div;
            if (sync_hold) nxt[15:3] = '0;
            m_div = nxt;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (cmp_on && rst_n) begin
            check(req_tag(pwr_fail, wave_en, rate_sel, sync_hold), wave_out, e_out, "wave_out");
            check("R5", wave_oe, e_oe, "wave_oe");
        end
    end

    // Watchdog.
    initial begin
        wait (cycles > 190000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 190000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int seed_sink;
        int n;
        seed_sink = $urandom(32'h1A2B3C4D);
        rst_n = 1'b0; tick_32k = 1'b1; rate_sel = 4'd1; wave_en = 1'b1;
        sync_hold = 1'b0; pwr_fail = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state of both outputs
        check("R1", wave_out, 1'b0, "wave_out in reset");
        check("R1", wave_oe, 1'b0, "wave_oe in reset");
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R8: release from hold at a known fast phase (L = 5)
        tick_32k = 1'b1; rate_sel = 4'd3; sync_hold = 1'b1;
        repeat (5) @(negedge clk);
        sync_hold = 1'b0;
        n = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (wave_out) begin n = i; break; end
        end
        check_int("R8", n, 4, "clocks to first slow rise after release");

        // R2, R3, R4, R5, R6, R7, R9: random stretches
        for (int blk = 0; blk < 400; blk++) begin
            int dens;
            dens     = $urandom_range(0, 3);
            rate_sel = 4'($urandom_range(0, 15));
            wave_en  = ($urandom_range(0, 5) != 0);
            pwr_fail = ($urandom_range(0, 6) == 0);
            sync_hold = ($urandom_range(0, 5) == 0);
            for (int c = 0; c < 50; c++) begin
                tick_32k = (dens == 0) ? 1'b1 : ($urandom_range(0, dens) == 0);
                if ($urandom_range(0, 40) == 0) rate_sel = 4'($urandom_range(0, 15));
                @(negedge clk);
            end
        end

        // R3: slowest rate, continuous ticks, measure the period
        do_reset();
        tick_32k = 1'b1; rate_sel = 4'd15; wave_en = 1'b1; pwr_fail = 1'b0; sync_hold = 1'b0;
        n = 0;
        for (int i = 1; i <= 40000; i++) begin
            @(negedge clk);
            if (wave_out) begin n = i; break; end
        end
        check_int("R3", n, 32769, "clocks to first rise at 0.5 Hz code");
        n = 0;
        for (int i = 1; i <= 40000; i++) begin
            @(negedge clk);
            if (!wave_out) begin n = i; break; end
        end
        check_int("R3", n, 32768, "high time at 0.5 Hz code");

        // R9: ticks stopped, other inputs wiggle, the level must not move
        rate_sel = 4'd2; tick_32k = 1'b0;
        @(negedge clk);
        sel_prev = wave_out;
        for (int i = 0; i < 20; i++) begin
            wave_en = 1'b1; pwr_fail = 1'b0;
            rate_sel = (i % 2 == 0) ? 4'd2 : 4'd7;
            @(negedge clk);
            rate_sel = 4'd2;
            @(negedge clk);
            @(negedge clk);
            check("R9", wave_out, sel_prev, "level with no ticks");
        end

        cmp_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule